// File: doc/BRIEF.md
# Power Domain Shutdown Sequencer

This block takes one gated CPU power domain from fully powered to fully off in a fixed order. A single start pulse launches the sequence. The block first isolates the domain's outputs and its SRAM. It then asks the L1 cache to power down and waits for the cache to acknowledge. After that it holds the domain in reset, stops its clock, and opens the two stages of the power switch one after the other. It reports done only once both stages' power-status inputs read low.

The sequencer acts only after an enabling configuration write. That write carries an unlock key and an enable bit. Each output change takes a clock cycle of its own, so no two steps ever land together. A seven-bit control word shows every domain control in a fixed bit layout for register readback.

Both wait states have an optional cycle limit. When a wait runs past it, the sequence stops and an error flag is raised, so the block does not hang.

Top module: `pd_shutdown_seq`

## Requirements
- R1: After reset, pwr_on, pwr_on2, dom_rst_n and sram_iso_n are 1; iso, sram_ckiso, clk_dis, l1_pdn_req, busy, done, err and ctrl_en are 0.
- R2: ctrl_word carries the domain controls at these bit positions: 0 = dom_rst_n, 1 = iso, 2 = pwr_on, 3 = pwr_on2, 4 = clk_dis, 5 = sram_ckiso, 6 = sram_iso_n.
- R3: ctrl_en changes only on a cfg_wr whose cfg_key equals UNLOCK_KEY, and it then takes the value of cfg_en. A start pulse while ctrl_en is 0 is ignored, and busy and every control output stay unchanged.
- R4: After an accepted start, iso rises first, then sram_ckiso rises, then sram_iso_n falls, each in a separate cycle.
- R5: Once the isolation steps are done, l1_pdn_req rises. dom_rst_n does not fall until l1_pdn_ack has been sampled high.
- R6: After the acknowledge, dom_rst_n falls, then clk_dis rises, then pwr_on falls, then pwr_on2 falls, each in a separate cycle.
- R7: done is a one-cycle pulse. It comes only after pwr_sta and pwr_sta2 have both been sampled low following the fall of pwr_on2, and busy drops in the same cycle.
- R8: busy is high from the cycle after an accepted start until done or err. A start pulse while busy has no effect on the sequence.
- R9: With TIMEOUT_EN set, a wait for the acknowledge or the power status that lasts WAIT_LIMIT cycles sets err and drops busy, with no done. An accepted start clears err.
- R10: At most one of the eight controls (the seven in ctrl_word and l1_pdn_req) changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_key | input | KEY_W | Unlock key presented with the write |
| cfg_en | input | 1 | Register-control enable value to write |
| start | input | 1 | Start pulse for the shutdown sequence |
| l1_pdn_ack | input | 1 | L1 power-down acknowledge |
| pwr_sta | input | 1 | Primary power-switch status |
| pwr_sta2 | input | 1 | Secondary power-switch status |
| ctrl_en | output | 1 | Register control enabled |
| dom_rst_n | output | 1 | Domain reset, active low |
| iso | output | 1 | Domain output isolation |
| pwr_on | output | 1 | Primary power switch on |
| pwr_on2 | output | 1 | Secondary power switch on |
| clk_dis | output | 1 | Domain clock disable |
| sram_ckiso | output | 1 | SRAM clock isolation |
| sram_iso_n | output | 1 | SRAM internal isolation, active low |
| l1_pdn_req | output | 1 | L1 power-down request |
| ctrl_word | output | 7 | Packed view of the domain controls |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed (one-cycle pulse) |
| err | output | 1 | Wait limit expired |

## Verification
The assertions assume the acknowledge and the power-status inputs are synchronous to clk and that the status inputs can be low only once the switches are commanded off. The bench models the domain to keep to this. It raises the acknowledge only a set number of cycles after it sees the request, and it lowers each status input only a set delay after the matching switch output falls. Delays of zero and several cycles are both exercised. The timeout cases simply leave one input stuck, which the assumptions permit.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
   localparam int CW_W       = 7;
   localparam int B_RST_N    = 0;
   localparam int B_ISO      = 1;
   localparam int B_PWR_ON   = 2;
   localparam int B_PWR_ON2  = 3;
   localparam int B_CLK_DIS  = 4;
   localparam int B_SRAM_CKI = 5;
   localparam int B_SRAM_ISN = 6;

   // powered-on domain: reset released, both switches on, SRAM not isolated
   localparam logic [CW_W-1:0] CW_POWERED =
      CW_W'((1 << B_RST_N) | (1 << B_PWR_ON) | (1 << B_PWR_ON2) | (1 << B_SRAM_ISN));

   typedef enum logic [3:0] {
      ST_IDLE, ST_ISO, ST_CKISO, ST_SRISO, ST_L1REQ, ST_L1WAIT,
      ST_RST, ST_CLKDIS, ST_PWR1, ST_PWR2, ST_STAWAIT
   } seq_state_t;
endpackage

// File: rtl/pd_ctrl_gate.sv
module pd_ctrl_gate #(
   parameter int                KEY_W      = 16,
   parameter logic [KEY_W-1:0]  UNLOCK_KEY = 16'hB5A3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [KEY_W-1:0] cfg_key,
   input  logic             cfg_en,
   output logic             en
);
   generate
      if (KEY_W < 1) begin : g_bad_key
         $error("KEY_W must be at least 1");
      end
   endgenerate

   logic key_ok;
   assign key_ok = cfg_wr && (cfg_key == UNLOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= 1'b0;
      else if (key_ok) en <= cfg_en;
   end

   // R3
   en_key_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(cfg_wr) && ($past(cfg_key) == UNLOCK_KEY)) |-> $stable(en));
endmodule

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
   parameter int WAIT_LIMIT = 1024,
   parameter bit TIMEOUT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   output logic expired
);
   localparam int CNT_W = (WAIT_LIMIT > 2) ? $clog2(WAIT_LIMIT) : 1;

   generate
      if (WAIT_LIMIT < 2) begin : g_bad_limit
         $error("WAIT_LIMIT must be at least 2");
      end
      if (TIMEOUT_EN) begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt <= '0;
            else if (!waiting) cnt <= '0;
            else if (!expired) cnt <= cnt + 1'b1;
         end
         assign expired = waiting && (cnt == CNT_W'(WAIT_LIMIT - 1));

         // R9
         cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cnt) < WAIT_LIMIT);
      end else begin : g_none
         assign expired = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
   import pd_seq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            en,
   input  logic            l1_ack,
   input  logic            sta1,
   input  logic            sta2,
   input  logic            expired,
   output logic            waiting,
   output logic [CW_W-1:0] cw,
   output logic            l1_req,
   output logic            busy,
   output logic            done,
   output logic            err
);
   seq_state_t st;

   assign busy    = (st != ST_IDLE);
   assign waiting = (st == ST_L1WAIT) || (st == ST_STAWAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cw     <= CW_POWERED;
         l1_req <= 1'b0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start && en) begin
               st  <= ST_ISO;
               err <= 1'b0;
            end
            ST_ISO:    begin cw[B_ISO]      <= 1'b1; st <= ST_CKISO;  end
            ST_CKISO:  begin cw[B_SRAM_CKI] <= 1'b1; st <= ST_SRISO;  end
            ST_SRISO:  begin cw[B_SRAM_ISN] <= 1'b0; st <= ST_L1REQ;  end
            ST_L1REQ:  begin l1_req         <= 1'b1; st <= ST_L1WAIT; end
            ST_L1WAIT: begin
               if (l1_ack) st <= ST_RST;
               else if (expired) begin err <= 1'b1; st <= ST_IDLE; end
            end
            ST_RST:    begin cw[B_RST_N]    <= 1'b0; st <= ST_CLKDIS; end
            ST_CLKDIS: begin cw[B_CLK_DIS]  <= 1'b1; st <= ST_PWR1;   end
            ST_PWR1:   begin cw[B_PWR_ON]   <= 1'b0; st <= ST_PWR2;   end
            ST_PWR2:   begin cw[B_PWR_ON2]  <= 1'b0; st <= ST_STAWAIT; end
            ST_STAWAIT: begin
               if (!sta1 && !sta2) begin done <= 1'b1; st <= ST_IDLE; end
               else if (expired) begin err <= 1'b1; st <= ST_IDLE; end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R10
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({l1_req, cw} ^ $past({l1_req, cw})) <= 1);
   // R5
   rst_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cw[B_RST_N]) |-> l1_req && cw[B_ISO] && !cw[B_SRAM_ISN]);
   // R6
   pwr_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cw[B_PWR_ON]) |-> cw[B_CLK_DIS] && !cw[B_RST_N]);
   // R7
   done_sta_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(!sta1 && !sta2) && !busy && !cw[B_PWR_ON2]);
   // R3
   no_en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !en) |=> !busy);
   // R9
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && $rose(err)));
endmodule

// File: rtl/pd_shutdown_seq.sv
module pd_shutdown_seq
   import pd_seq_pkg::*;
#(
   parameter int               KEY_W      = 16,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hB5A3,
   parameter int               WAIT_LIMIT = 1024,
   parameter bit               TIMEOUT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [KEY_W-1:0] cfg_key,
   input  logic             cfg_en,
   input  logic             start,
   input  logic             l1_pdn_ack,
   input  logic             pwr_sta,
   input  logic             pwr_sta2,
   output logic             ctrl_en,
   output logic             dom_rst_n,
   output logic             iso,
   output logic             pwr_on,
   output logic             pwr_on2,
   output logic             clk_dis,
   output logic             sram_ckiso,
   output logic             sram_iso_n,
   output logic             l1_pdn_req,
   output logic [6:0]       ctrl_word,
   output logic             busy,
   output logic             done,
   output logic             err
);
   logic            waiting, expired;
   logic [CW_W-1:0] cw;

   pd_ctrl_gate #(.KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)) u_gate (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_key(cfg_key),
      .cfg_en(cfg_en), .en(ctrl_en));

   pd_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT), .TIMEOUT_EN(TIMEOUT_EN)) u_timer (
      .clk(clk), .rst_n(rst_n), .waiting(waiting), .expired(expired));

   pd_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .en(ctrl_en),
      .l1_ack(l1_pdn_ack), .sta1(pwr_sta), .sta2(pwr_sta2),
      .expired(expired), .waiting(waiting), .cw(cw), .l1_req(l1_pdn_req),
      .busy(busy), .done(done), .err(err));

   assign ctrl_word  = cw;
   assign dom_rst_n  = cw[B_RST_N];
   assign iso        = cw[B_ISO];
   assign pwr_on     = cw[B_PWR_ON];
   assign pwr_on2    = cw[B_PWR_ON2];
   assign clk_dis    = cw[B_CLK_DIS];
   assign sram_ckiso = cw[B_SRAM_CKI];
   assign sram_iso_n = cw[B_SRAM_ISN];

   // R4
   iso_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_iso_n) |-> iso && sram_ckiso);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/pd_shutdown_seq_tb.sv
`timescale 1ns/1ps
module pd_shutdown_seq_tb;
   localparam int               KEY_W = 16;
   localparam logic [KEY_W-1:0] KEY   = 16'hB5A3;
   localparam int               LIM   = 16;

   logic clk = 0, rst_n = 0, cfg_wr = 0, cfg_en = 0, start = 0;
   logic [KEY_W-1:0] cfg_key = '0;
   logic ack = 0, sta1 = 1, sta2 = 1;
   logic ctrl_en, dom_rst_n, iso, pwr_on, pwr_on2, clk_dis, sram_ckiso, sram_iso_n;
   logic l1_pdn_req, busy, done, err;
   logic [6:0] ctrl_word;

   int errors = 0, checks = 0;
   bit wd_fired = 0;

   always #2 clk = ~clk;

   pd_shutdown_seq #(.KEY_W(KEY_W), .UNLOCK_KEY(KEY), .WAIT_LIMIT(LIM), .TIMEOUT_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_key(cfg_key), .cfg_en(cfg_en),
      .start(start), .l1_pdn_ack(ack), .pwr_sta(sta1), .pwr_sta2(sta2),
      .ctrl_en(ctrl_en), .dom_rst_n(dom_rst_n), .iso(iso), .pwr_on(pwr_on),
      .pwr_on2(pwr_on2), .clk_dis(clk_dis), .sram_ckiso(sram_ckiso),
      .sram_iso_n(sram_iso_n), .l1_pdn_req(l1_pdn_req), .ctrl_word(ctrl_word),
      .busy(busy), .done(done), .err(err));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // packed 8-bit view: {l1_pdn_req, sram_iso_n, sram_ckiso, clk_dis, pwr_on2, pwr_on, iso, dom_rst_n}
   function automatic logic [7:0] snap();
      return {l1_pdn_req, sram_iso_n, sram_ckiso, clk_dis, pwr_on2, pwr_on, iso, dom_rst_n};
   endfunction

   task automatic do_reset();
      rst_n = 0; start = 0; cfg_wr = 0; ack = 0; sta1 = 1; sta2 = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic [KEY_W-1:0] k, input logic v);
      cfg_wr = 1; cfg_key = k; cfg_en = v;
      @(negedge clk);
      cfg_wr = 0;
      @(negedge clk);
   endtask

   // Runs one shutdown with a bench model of the domain; checks order and timing.
   task automatic run_seq(input int ack_dly, input int sta_dly, input bit restart_mid, input string tag);
      int  order[8] = '{1, 5, 6, 7, 0, 4, 2, 3};
      int  ev[$];
      int  evc[$];
      int  ack_cyc = -1, rst_cyc = -1, sta_cyc = -1, done_cyc = -1, dones = 0;
      int  req_cnt = 0, off_cnt = 0, multi = 0, busy_gap = 0;
      logic [7:0] prev, cur;
      prev = snap();
      start = 1; @(negedge clk); start = 0;
      for (int c = 1; c < 200; c++) begin
         cur = snap();
         if ($countones(cur ^ prev) > 1) multi++;
         for (int b = 0; b < 8; b++) if (cur[b] != prev[b]) begin ev.push_back(b); evc.push_back(c); end
         if (!dom_rst_n && prev[0]) rst_cyc = c;
         if (done) begin dones++; if (done_cyc < 0) done_cyc = c; end
         if (done_cyc < 0 && !busy) busy_gap++;
         prev = cur;
         if (l1_pdn_req) req_cnt++;
         if (l1_pdn_req && req_cnt > ack_dly && !ack) begin ack = 1; ack_cyc = c; end
         if (!pwr_on2) off_cnt++;
         if (!pwr_on2 && off_cnt > sta_dly && sta1) begin sta1 = 0; sta2 = 0; sta_cyc = c; end
         if (restart_mid && c == 6) start = 1; else start = 0;
         @(negedge clk);
         if (done_cyc >= 0 && c > done_cyc + 3) break;
      end
      chk(ev.size() == 8, {tag, " event count"}, ev.size(), 8);
      for (int i = 0; i < 8 && i < ev.size(); i++)
         chk(ev[i] == order[i], {tag, " step order (R4 R6)"}, ev[i], order[i]);
      chk(multi == 0, {tag, " one change per edge R10"}, multi, 0);
      chk(rst_cyc > ack_cyc && ack_cyc > 0, {tag, " reset after ack R5"}, rst_cyc, ack_cyc + 1);
      chk(done_cyc > sta_cyc && sta_cyc > 0, {tag, " done after status R7"}, done_cyc, sta_cyc + 1);
      chk(dones == 1, {tag, " single done pulse R7 R8"}, dones, 1);
      chk(busy_gap == 0 && !busy && !err, {tag, " busy until done R8"}, busy_gap, 0);
   endtask

   task automatic t_reset();
      do_reset();
      chk(snap() == 8'b0100_1101, "R1 reset controls", snap(), 8'b0100_1101);
      chk({busy, done, err, ctrl_en} == 4'b0, "R1 reset status", {busy, done, err, ctrl_en}, 0);
   endtask

   task automatic t_layout();
      do_reset();
      chk(ctrl_word == {sram_iso_n, sram_ckiso, clk_dis, pwr_on2, pwr_on, iso, dom_rst_n},
          "R2 layout at reset", ctrl_word, 7'h4D);
      cfg_write(KEY, 1);
      run_seq(0, 0, 0, "R2 run");
      chk(ctrl_word == 7'b0110_010, "R2 layout after shutdown", ctrl_word, 7'b0110010);
   endtask

   task automatic t_gate();
      do_reset();
      cfg_write(KEY ^ 16'h0001, 1);
      chk(ctrl_en == 0, "R3 wrong key", ctrl_en, 0);
      start = 1; @(negedge clk); start = 0; @(negedge clk);
      chk(!busy && snap() == 8'h4D, "R3 start ignored when disabled", {busy, snap()}, 8'h4D);
      cfg_write(KEY, 1);
      chk(ctrl_en == 1, "R3 key enables", ctrl_en, 1);
      cfg_write(KEY, 0);
      chk(ctrl_en == 0, "R3 key disables", ctrl_en, 0);
   endtask

   task automatic t_run_fast();
      do_reset(); cfg_write(KEY, 1);
      run_seq(0, 0, 0, "R4 R5 R6 fast");
   endtask

   task automatic t_run_slow();
      do_reset(); cfg_write(KEY, 1);
      run_seq(5, 7, 1, "R8 slow with restart");
   endtask

   task automatic t_timeout_ack();
      do_reset(); cfg_write(KEY, 1);
      start = 1; @(negedge clk); start = 0;
      repeat (LIM + 8) @(negedge clk);
      chk(err && !busy, "R9 ack timeout err", {err, busy}, 2);
      chk(dom_rst_n && pwr_on, "R5 reset held without ack", {dom_rst_n, pwr_on}, 3);
      ack = 1;
      start = 1; @(negedge clk); start = 0;
      chk(!err && busy, "R9 err cleared by start", {err, busy}, 1);
   endtask

   task automatic t_timeout_sta();
      int dn = 0;
      do_reset(); cfg_write(KEY, 1);
      ack = 1;
      start = 1; @(negedge clk); start = 0;
      for (int i = 0; i < LIM + 20; i++) begin @(negedge clk); if (done) dn++; end
      chk(err && !busy && dn == 0, "R9 status timeout", {err, busy, dn[0]}, 4);
      chk(!pwr_on2, "R7 switches off while status stuck", pwr_on2, 0);
   endtask

   initial begin
      t_reset();
      t_layout();
      t_gate();
      t_run_fast();
      t_run_slow();
      t_timeout_ack();
      t_timeout_sta();
      if (wd_fired) begin errors++; checks++; end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      wd_fired = 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      errors++; checks++;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule